// File: doc/BRIEF.md
# Weighted High/Low Packet Arbiter

This block decides, one packet at a time, which of two transmit queues supplies the next packet: an urgent (high) queue or a background (low) queue. It watches a "has data" flag from each queue and a one-cycle completion strobe from the transmitter. It drives a registered grant that names the selected queue and holds it for the whole packet.

A 3-bit ratio code sets the shape of each service round. Codes 0 to 6 give a fixed number of high packets followed by a single low packet. Code 0 gives one high packet per round, and code n from 1 to 6 gives 2·n. Code 7 turns the rounds off and gives the high queue strict priority.

The round counter recovers on its own when either queue runs dry. If the high queue empties early, the next round starts fresh. If the low queue has nothing waiting when its turn comes, the high queue simply begins a new round.

Top module: `hilo_weighted_arb`

## Requirements
- R1: The grant output is zero or one-hot, with bit 0 meaning the high queue and bit 1 meaning the low queue.
- R2: While a grant is held, it changes only at a clock edge where the completion strobe is sampled high. It is constant for every other cycle of the packet.
- R3: When a decision is taken and neither queue has data, the grant is zero after that edge. It stays zero until a queue reports data.
- R4: With both queues busy, ratio code c (0 to 6) serves N high packets and then one low packet, where N is 1 for code 0 and 2·c otherwise (2, 4, 6, 8, 10, 12).
- R5: With code 7, every decision picks the high queue whenever it has data. The low queue is picked only while the high queue is empty.
- R6: If the high queue is empty at a decision before its quota is reached, the high count returns to zero. The next high packet starts a full new quota.
- R7: If the quota is reached and the low queue is empty, the high queue is granted again with a fresh count. The low packet then comes after another full quota.
- R8: The ratio code is sampled only at the decision edge, so a code change made during a packet applies to the decision at that packet's end.
- R9: During synchronous active-low reset the grant is zero and the high count is zero.
- R10: From the idle state (no grant), a grant is issued at the next edge after data appears. The high queue wins if it has data.
- R11: Finishing a low packet starts a new round, so the following high run has the full quota.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_avail | input | 1 | High queue has at least one packet |
| lo_avail | input | 1 | Low queue has at least one packet |
| pkt_done | input | 1 | One-cycle strobe: the granted packet has finished |
| ratio_code | input | 3 | Round shape: 0..6 weighted, 7 strict priority |
| grant | output | 2 | Bit 0 high queue, bit 1 low queue, zero when idle |

## Verification
The bench goes after the round boundaries. It runs the smallest (1:1) and largest (12:1) ratios to full length, where an off-by-one in the quota would slip the low packet early or late. It drains the high queue mid-round and then refills it; a design that kept the old count would hand out the low packet after only two high packets instead of four. It holds the low queue empty at its turn and fills it during the next run; a counter that saturated instead of restarting would grant low one packet too soon. It also changes the ratio code mid-packet, which catches a design that latched the code at round start. Every cycle inside a packet is compared against the held grant, so a grant that moved before the completion strobe is reported.

// File: rtl/wq_arb_pkg.sv
// Shared types for the weighted high/low packet arbiter.
package wq_arb_pkg;
    // Grant encoding: bit 0 high queue, bit 1 low queue.
    typedef enum logic [1:0] {
        GNT_NONE = 2'b00,
        GNT_HI   = 2'b01,
        GNT_LO   = 2'b10
    } gnt_e;
endpackage

// File: rtl/wq_weight_decode.sv
// Maps the ratio code to a high-packet quota per round.
// Assumes: the all-ones code selects strict priority; code 0 gives a quota of 1,
// and any other code gives code*STEP.
module wq_weight_decode #(
    parameter int CODE_W = 3,
    parameter int STEP   = 2,
    parameter int CNT_W  = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  quota,
    output logic              strict
);
    // Quota and strict-mode decode.
    always_comb begin
        strict = &code;
        if (code == '0)
            quota = CNT_W'(1);
        else
            quota = CNT_W'(code) * CNT_W'(STEP);
    end
endmodule

// File: rtl/wq_pick.sv
// Combinational choice of the next queue and the next high count.
// Assumes: done_cnt already counts the packet that just finished; the quota is
// at least 1.
module wq_pick
    import wq_arb_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             hi_avail,
    input  logic             lo_avail,
    input  logic             strict,
    input  logic [CNT_W-1:0] quota,
    input  logic [CNT_W-1:0] done_cnt,
    output gnt_e             nxt_gnt,
    output logic [CNT_W-1:0] nxt_cnt
);
    logic quota_met;

    // Quota reached test.
    assign quota_met = (done_cnt >= quota);

    // Priority selection and count update.
    always_comb begin
        nxt_gnt = GNT_NONE;
        nxt_cnt = '0;
        if (strict) begin
            if (hi_avail)      nxt_gnt = GNT_HI;
            else if (lo_avail) nxt_gnt = GNT_LO;
        end else if (quota_met && lo_avail) begin
            nxt_gnt = GNT_LO;
        end else if (hi_avail) begin
            nxt_gnt = GNT_HI;
            nxt_cnt = quota_met ? '0 : done_cnt;
        end else if (lo_avail) begin
            nxt_gnt = GNT_LO;
        end
    end
endmodule

// File: rtl/wq_round_cnt.sv
// Holds the count of high packets served in the current round.
// Assumes: load_en pulses only at decision edges.
module wq_round_cnt #(
    parameter int CNT_W   = 4,
    parameter int MAX_CNT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);
    // Count register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (load_en) cnt <= load_val;
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(MAX_CNT));
endmodule

// File: rtl/hilo_weighted_arb.sv
// Packet-level arbiter between a high and a low transmit queue.
// Assumes: pkt_done is a single-cycle strobe raised only while a grant is held,
// and the queue flags already reflect the finished packet in that cycle.
module hilo_weighted_arb
    import wq_arb_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_avail,
    input  logic              lo_avail,
    input  logic              pkt_done,
    input  logic [CODE_W-1:0] ratio_code,
    output logic [1:0]        grant
);
    localparam int MAX_QUOTA = STEP * ((1 << CODE_W) - 2);
    localparam int CNT_W     = $clog2(MAX_QUOTA + 1);

    gnt_e             grant_q;
    gnt_e             nxt_gnt;
    logic             decide;
    logic             strict;
    logic [CNT_W-1:0] quota;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] done_cnt;
    logic [CNT_W-1:0] nxt_cnt;

    // A decision is taken when idle or when the held packet finishes.
    assign decide = (grant_q == GNT_NONE) || pkt_done;

    // Count including the packet that just finished; a low packet ends a round.
    always_comb begin
        if (grant_q == GNT_HI && pkt_done) done_cnt = cnt_q + CNT_W'(1);
        else if (grant_q == GNT_LO)        done_cnt = '0;
        else                               done_cnt = cnt_q;
    end

    wq_weight_decode #(.CODE_W(CODE_W), .STEP(STEP), .CNT_W(CNT_W)) u_decode (
        .code   (ratio_code),
        .quota  (quota),
        .strict (strict)
    );

    wq_pick #(.CNT_W(CNT_W)) u_pick (
        .hi_avail (hi_avail),
        .lo_avail (lo_avail),
        .strict   (strict),
        .quota    (quota),
        .done_cnt (done_cnt),
        .nxt_gnt  (nxt_gnt),
        .nxt_cnt  (nxt_cnt)
    );

    wq_round_cnt #(.CNT_W(CNT_W), .MAX_CNT(MAX_QUOTA)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (decide),
        .load_val (nxt_cnt),
        .cnt      (cnt_q)
    );

    // Grant register, updated only at decision edges.
    always_ff @(posedge clk) begin
        if (!rst_n)      grant_q <= GNT_NONE;
        else if (decide) grant_q <= nxt_gnt;
    end

    assign grant = grant_q;

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q != GNT_NONE && !pkt_done) |=> $stable(grant_q));

    // R3
    idle_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && !hi_avail && !lo_avail) |=> (grant_q == GNT_NONE));

    // R5
    strict_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && (&ratio_code) && hi_avail) |=> (grant_q == GNT_HI));

    // R10
    idle_hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q == GNT_NONE && hi_avail) |=> (grant_q == GNT_HI));
endmodule

// File: tb/hilo_weighted_arb_bench.sv
module hilo_weighted_arb_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hi_avail, lo_avail;
    logic       pkt_done = 1'b0;
    logic [2:0] ratio_code = 3'd0;
    logic [1:0] grant;

    int hi_left = 0;
    int lo_left = 0;
    int n_chk = 0;
    int n_fail = 0;
    int m_grant = 0;
    int m_cnt = 0;
    int    exp_q[$];
    string tag_q[$];

    localparam int PKT_LEN = 2;

    always #10 clk = ~clk;

    always_comb begin
        hi_avail = (hi_left > 0);
        lo_avail = (lo_avail_f());
    end

    function automatic logic lo_avail_f();
        return lo_left > 0;
    endfunction

    hilo_weighted_arb u_hilo_weighted_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .hi_avail   (hi_avail),
        .lo_avail   (lo_avail),
        .pkt_done   (pkt_done),
        .ratio_code (ratio_code),
        .grant      (grant)
    );

    function automatic int quota_of(int c);
        return (c == 0) ? 1 : 2 * c;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: grant=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model of one decision, pushed to the scoreboard.
    task automatic model_step(bit done, string tag);
        int c1;
        int g;
        int nc;
        bit hi, lo;
        hi = hi_left > 0;
        lo = lo_left > 0;
        if (m_grant == 1 && done) c1 = m_cnt + 1;
        else if (m_grant == 2)    c1 = 0;
        else                      c1 = m_cnt;
        g = 0; nc = 0;
        if (ratio_code == 3'd7) begin
            g = hi ? 1 : (lo ? 2 : 0);
        end else if (c1 >= quota_of(int'(ratio_code)) && lo) begin
            g = 2;
        end else if (hi) begin
            g = 1;
            nc = (c1 >= quota_of(int'(ratio_code))) ? 0 : c1;
        end else if (lo) begin
            g = 2;
        end
        m_grant = g;
        m_cnt = nc;
        exp_q.push_back(g);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares each decision's result mid-cycle after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, int'(grant), e);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        hi_left = 0; lo_left = 0; pkt_done = 1'b0;
        m_grant = 0; m_cnt = 0;
        repeat (2) @(negedge clk);
        check("R9 reset", int'(grant), 0);
        rst_n = 1'b1;
    endtask

    task automatic load(int h, int l, int c, string tag);
        @(negedge clk);
        hi_left = h; lo_left = l; ratio_code = 3'(c);
        if (m_grant == 0) model_step(1'b0, tag);
    endtask

    // Driver: holds a packet, checks the grant holds (R2), then ends it.
    task automatic send_packet(string tag);
        for (int i = 0; i < PKT_LEN; i++) begin
            @(negedge clk);
            check("R2 hold", int'(grant), m_grant);
        end
        @(negedge clk);
        pkt_done = 1'b1;
        if (m_grant == 1) hi_left--;
        else if (m_grant == 2) lo_left--;
        model_step(1'b1, tag);
        @(negedge clk);
        pkt_done = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R4: 1:1 ratio, R11 fresh round after each low
        load(6, 6, 0, "R10 idle start");
        for (int i = 0; i < 8; i++) send_packet("R4 R11 code0");
        do_reset();
        load(9, 3, 2, "R10 idle start");
        for (int i = 0; i < 10; i++) send_packet("R4 code2");
        do_reset();
        load(13, 1, 6, "R10 idle start");
        for (int i = 0; i < 14; i++) send_packet("R4 code6");
        // R5 strict priority
        do_reset();
        load(3, 3, 7, "R5 strict start");
        for (int i = 0; i < 6; i++) send_packet("R5 strict");
        // R6 high empties early, then R3 idle
        do_reset();
        load(2, 0, 2, "R10 idle start");
        send_packet("R6 partial");
        send_packet("R3 drain");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R3 idle", int'(grant), 0);
        end
        load(5, 2, 2, "R6 refill");
        for (int i = 0; i < 5; i++) send_packet("R6 fresh quota");
        // R7 low empty at its turn
        do_reset();
        load(5, 0, 1, "R10 idle start");
        send_packet("R7 first");
        send_packet("R7 low empty turn");
        @(negedge clk);
        lo_left = 2;
        for (int i = 0; i < 3; i++) send_packet("R7 restart");
        // R8 code change during a packet
        do_reset();
        load(10, 2, 4, "R10 idle start");
        @(negedge clk);
        ratio_code = 3'd0;
        send_packet("R8 code change");
        send_packet("R8 after change");
        send_packet("R8 after change");
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule